// File: doc/BRIEF.md
# Nibble-Field Prioritised Interrupt Controller

This block gathers 28 peripheral interrupt sources and tells the processor which one to serve. Vector 0 is a spurious slot. Vectors 1 to 28 belong to the sources, and each source has one vector. Each source owns a 4-bit field in one of four 32-bit control words. The low three bits of a field hold the source's priority, and a priority of zero turns the source off. The top bit of a field is a commit strobe. A write loads the priority bits only where the commit bit is set, so software can change one source without a read-modify-write of its neighbours.

Six sources are external inputs: vectors 1 to 4, 26 and 27. The block detects an edge on each of them and holds it as a pending flag. A polarity word chooses the active edge for each external input. A committing write to an external field clears its pending flag, which is how software acknowledges or masks that input. The other sources are internal and level-sensitive: each one counts as active for as long as its input is high. On every clock the block reports the highest active priority and the vector that owns it. The interface is a plain register bus plus the raw source lines, with no handshake at the edge of the block.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset all priorities are 0, no edge is pending, every polarity bit is 0 (falling edge), and the outputs read level 0 and vector 0.
- R2: Address 0 to 3 selects a control word. Vector v sits in word (v-1)/8 at bits [31-4*((v-1)%8) -: 4], so vector 1 is in bits 31:28 of word 0. Address 4 is the polarity word, whose bits 5:0 belong to vectors 1, 2, 3, 4, 26 and 27 in that order. Bits 15:0 of word 3 and every other address read 0, and writes to them have no effect.
- R3: A write to a field whose bit 3 is 1 loads bits 2:0 of that field as the new priority. A field written with bit 3 at 0 keeps its previous priority.
- R4: A field reads back with the priority in bits 2:0. Bit 3 shows the pending flag for external vectors and always reads 0 for internal vectors.
- R5: An external vector sets its pending flag on the edge chosen by its polarity bit (1 = rising, 0 = falling). The flag stays set after the input returns to its idle level.
- R6: An edge that arrives while the vector's priority is 0 is not recorded.
- R7: A committing write to an external field clears its pending flag. If an enabled edge arrives in the same cycle, the flag is set instead. Writing 0x88888888 to all four words disables every source.
- R8: An internal vector is active while its input is high and its priority is nonzero. It does not latch.
- R9: The output gives the highest priority among the active vectors and the vector that holds it. When two vectors share that priority, the lower vector number wins. When no vector is active, the output is level 0 and vector 0.
- R10: A source input that is sampled at clock edge k shows up at the output at edge k+1. A write that is captured at edge k has the same latency. Read data follows the stored state combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| src_in | input | 28 | Source lines; bit i belongs to vector i+1 |
| irq_level | output | 3 | Highest active priority, 0 when idle |
| irq_vector | output | 5 | Vector number of that priority, 0 when idle |

## Verification
Read data depends only on the stored state. It is therefore compared one time unit after the falling edge that follows the capturing rising edge. The interrupt output lags by one more rising edge, because the source lines are registered first and the arbitration result is registered after that. The directed checks wait exactly two falling edges after a source change, and one falling edge after a write returns, before they compare the output. The bench also runs a cycle model that updates on each rising edge from the same inputs, so the random phase can compare both the output and the read data on every falling edge.

// File: rtl/pic_pkg.sv
package pic_pkg;

  // number of external vectors among vectors 1..upto
  function automatic int ext_count(input logic [31:0] mask, input int upto);
    int n;
    n = 0;
    for (int v = 1; v <= 31; v++)
      if (v <= upto && mask[v]) n++;
    return n;
  endfunction

  // polarity bit index of vector v: external vectors below it
  function automatic int ext_index(input logic [31:0] mask, input int v);
    return ext_count(mask, v - 1);
  endfunction

endpackage

// File: rtl/pic_slot.sv
module pic_slot #(
  parameter int PRIO_W = 3,
  parameter bit IS_EXT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [PRIO_W-1:0] wr_prio,
  input  logic              src_now,
  input  logic              src_prev,
  input  logic              rise_sel,
  output logic [PRIO_W-1:0] prio_o,
  output logic              pend_o,
  output logic              act_o
);

  logic [PRIO_W-1:0] prio_q;
  logic              enabled;

  assign enabled = (prio_q != '0);
  assign prio_o  = prio_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      prio_q <= '0;
    else if (commit) prio_q <= wr_prio;
  end

  generate
    if (IS_EXT) begin : g_edge
      logic pend_q;
      logic hit;
      assign hit = rise_sel ? (src_now & ~src_prev) : (~src_now & src_prev);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              pend_q <= 1'b0;
        else if (hit && enabled) pend_q <= 1'b1;
        else if (commit)         pend_q <= 1'b0;
      end
      assign pend_o = pend_q;
      assign act_o  = pend_q & enabled;
    end else begin : g_level
      logic unused_edge_inputs;
      assign unused_edge_inputs = src_now ^ rise_sel;
      assign pend_o = 1'b0;
      assign act_o  = src_prev & enabled;
    end
  endgenerate

endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int NUM_SRC = 28,
  parameter int PRIO_W  = 3,
  parameter int VEC_W   = 5
) (
  input  logic [NUM_SRC-1:0]             act,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
  output logic [PRIO_W-1:0]              best_lvl,
  output logic [VEC_W-1:0]               best_vec
);

  // strict greater-than keeps the lowest vector on a tie
  always_comb begin
    best_lvl = '0;
    best_vec = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (act[i] && (prio[i] > best_lvl)) begin
        best_lvl = prio[i];
        best_vec = VEC_W'(i + 1);
      end
    end
  end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import pic_pkg::*;
#(
  parameter int          NUM_SRC  = 28,
  parameter int          PRIO_W   = 3,
  parameter int          DATA_W   = 32,
  parameter int          ADDR_W   = 3,
  parameter logic [31:0] EXT_MASK = 32'h0C00001E
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               bus_wr,
  input  logic [ADDR_W-1:0]                  bus_addr,
  input  logic [DATA_W-1:0]                  bus_wdata,
  output logic [DATA_W-1:0]                  bus_rdata,
  input  logic [NUM_SRC-1:0]                 src_in,
  output logic [PRIO_W-1:0]                  irq_level,
  output logic [$clog2(NUM_SRC+1)-1:0]       irq_vector
);

  localparam int FIELD_W  = PRIO_W + 1;
  localparam int FPR      = DATA_W / FIELD_W;
  localparam int NUM_REG  = (NUM_SRC + FPR - 1) / FPR;
  localparam int NUM_EXT  = ext_count(EXT_MASK, NUM_SRC);
  localparam int VEC_W    = $clog2(NUM_SRC + 1);
  localparam int POL_ADDR = NUM_REG;

  logic [NUM_SRC-1:0]              src_q;
  logic [NUM_EXT-1:0]              pol_q;
  logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_all;
  logic [NUM_SRC-1:0]              pend_all;
  logic [NUM_SRC-1:0]              act_all;
  logic [NUM_REG-1:0][DATA_W-1:0]  reg_img;
  logic [PRIO_W-1:0]               arb_lvl;
  logic [VEC_W-1:0]                arb_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      pol_q <= '0;
    end else begin
      src_q <= src_in;
      if (bus_wr && bus_addr == ADDR_W'(POL_ADDR))
        pol_q <= bus_wdata[NUM_EXT-1:0];
    end
  end

  generate
    for (genvar v = 1; v <= NUM_SRC; v++) begin : g_src
      localparam int R  = (v - 1) / FPR;
      localparam int LO = DATA_W - FIELD_W * ((v - 1) % FPR + 1);
      logic commit;
      logic rise_sel;
      assign commit = bus_wr && (bus_addr == ADDR_W'(R)) && bus_wdata[LO+PRIO_W];
      if (EXT_MASK[v]) begin : g_pol
        assign rise_sel = pol_q[ext_index(EXT_MASK, v)];
      end else begin : g_nopol
        assign rise_sel = 1'b0;
      end
      pic_slot #(.PRIO_W(PRIO_W), .IS_EXT(EXT_MASK[v])) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .wr_prio  (bus_wdata[LO +: PRIO_W]),
        .src_now  (src_in[v-1]),
        .src_prev (src_q[v-1]),
        .rise_sel (rise_sel),
        .prio_o   (prio_all[v-1]),
        .pend_o   (pend_all[v-1]),
        .act_o    (act_all[v-1])
      );
    end

    for (genvar r = 0; r < NUM_REG; r++) begin : g_img
      for (genvar f = 0; f < FPR; f++) begin : g_fld
        localparam int V  = r * FPR + f + 1;
        localparam int LO = DATA_W - FIELD_W * (f + 1);
        if (V <= NUM_SRC) begin : g_used
          assign reg_img[r][LO +: FIELD_W] = {pend_all[V-1], prio_all[V-1]};
        end else begin : g_spare
          assign reg_img[r][LO +: FIELD_W] = '0;
        end
      end
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    for (int r = 0; r < NUM_REG; r++)
      if (bus_addr == ADDR_W'(r)) bus_rdata = reg_img[r];
    if (bus_addr == ADDR_W'(POL_ADDR)) bus_rdata = DATA_W'(pol_q);
  end

  pic_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W)) u_arb (
    .act      (act_all),
    .prio     (prio_all),
    .best_lvl (arb_lvl),
    .best_vec (arb_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_level  <= '0;
      irq_vector <= '0;
    end else begin
      irq_level  <= arb_lvl;
      irq_vector <= arb_vec;
    end
  end

endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
  parameter int NUM_SRC = 28,
  parameter int PRIO_W  = 3,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 3,
  parameter int NUM_EXT = 6,
  parameter int VEC_W   = 5,
  parameter int POL_ADDR = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [PRIO_W-1:0] irq_level,
  input logic [VEC_W-1:0]  irq_vector,
  input logic [PRIO_W-1:0] prio_v1,
  input logic              pend_v1,
  input logic [NUM_EXT-1:0] pol
);

  logic wr_w0;
  assign wr_w0 = bus_wr && (bus_addr == '0);

  AST_IDLE_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level == '0) |-> (irq_vector == '0)); // R9
  AST_VECTOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != '0) |-> (irq_vector != '0 && irq_vector <= VEC_W'(NUM_SRC))); // R9
  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_w0 && !bus_wdata[DATA_W-1]) |=> $stable(prio_v1)); // R3
  AST_FIELD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_w0 && bus_wdata[DATA_W-1]) |=> (prio_v1 == $past(bus_wdata[DATA_W-2 -: PRIO_W]))); // R3
  AST_NO_LATCH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_v1 == '0 && !pend_v1) |=> !pend_v1); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_w0 && bus_wdata[DATA_W-1] && prio_v1 == '0) |=> !pend_v1); // R7
  AST_POL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(POL_ADDR)) |=> (pol == $past(bus_wdata[NUM_EXT-1:0]))); // R5

endmodule

bind prio_irq_ctrl pic_checker #(
  .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .NUM_EXT(NUM_EXT), .VEC_W(VEC_W), .POL_ADDR(POL_ADDR)
) u_pic_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .irq_level  (irq_level),
  .irq_vector (irq_vector),
  .prio_v1    (prio_all[0]),
  .pend_v1    (pend_all[0]),
  .pol        (pol_q)
);

// File: tb/prio_irq_ctrl_bench.sv
module prio_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 28;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [27:0] src_in = '0;
  wire  [31:0] bus_rdata;
  wire  [2:0]  irq_level;
  wire  [4:0]  irq_vector;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
    .irq_level(irq_level), .irq_vector(irq_vector)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---- reference model built from the requirements ----
  int          m_prio [1:NSRC];
  bit          m_pend [1:NSRC];
  logic [27:0] m_srcq = '0;
  logic [5:0]  m_pol = '0;
  int          exp_lvl = 0;
  int          exp_vec = 0;

  function automatic bit f_ext(input int v);
    return (v >= 1 && v <= 4) || v == 26 || v == 27;
  endfunction
  function automatic int f_pidx(input int v);
    return (v <= 4) ? v - 1 : v - 22;
  endfunction
  function automatic int f_reg(input int v);
    return (v - 1) / 8;
  endfunction
  function automatic int f_lo(input int v);
    return 28 - 4 * ((v - 1) % 8);
  endfunction
  function automatic logic [31:0] m_read(input logic [2:0] a);
    logic [31:0] r;
    r = '0;
    if (a == 3'd4) r = {26'd0, m_pol};
    else if (a < 3'd4)
      for (int v = 1; v <= NSRC; v++)
        if (f_reg(v) == int'(a))
          r[f_lo(v) +: 4] = {f_ext(v) ? m_pend[v] : 1'b0, 3'(m_prio[v])};
    return r;
  endfunction

  initial for (int v = 1; v <= NSRC; v++) begin m_prio[v] = 0; m_pend[v] = 0; end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int v = 1; v <= NSRC; v++) begin m_prio[v] = 0; m_pend[v] = 0; end
      m_srcq = '0; m_pol = '0; exp_lvl = 0; exp_vec = 0;
    end else begin
      exp_lvl = 0; exp_vec = 0;
      for (int v = 1; v <= NSRC; v++) begin
        bit act;
        act = (m_prio[v] != 0) && (f_ext(v) ? m_pend[v] : m_srcq[v-1]);
        if (act && m_prio[v] > exp_lvl) begin exp_lvl = m_prio[v]; exp_vec = v; end
      end
      for (int v = 1; v <= NSRC; v++) begin
        bit cm, ed;
        cm = bus_wr && (int'(bus_addr) == f_reg(v)) && bus_wdata[f_lo(v) + 3];
        if (f_ext(v)) begin
          ed = m_pol[f_pidx(v)] ? (src_in[v-1] && !m_srcq[v-1]) : (!src_in[v-1] && m_srcq[v-1]);
          if (ed && m_prio[v] != 0) m_pend[v] = 1;
          else if (cm) m_pend[v] = 0;
        end
        if (cm) m_prio[v] = int'(bus_wdata[f_lo(v) +: 3]);
      end
      if (bus_wr && bus_addr == 3'd4) m_pol = bus_wdata[5:0];
      m_srcq = src_in;
    end
  end

  // ---- checking helpers ----
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_out(input int lvl, input int vec, input string tag);
    chk({tag, " level"}, 32'(irq_level), 32'(lvl));
    chk({tag, " vector"}, 32'(irq_vector), 32'(vec));
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog: actual %0d cycles expected completion earlier", 50000);
      summary();
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(20240611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    #1 chk_out(0, 0, "R1");
    for (int a = 0; a < 5; a++) rd_chk(3'(a), 32'h0, "R1 register clear");

    // R3 / R4 commit writes
    wr(3'd0, 32'hD000_0000);
    wr(3'd1, 32'hD000_0000);
    rd_chk(3'd0, 32'h5000_0000, "R3 load v1");
    rd_chk(3'd1, 32'h5000_0000, "R4 internal bit3 zero");
    wr(3'd0, 32'h7000_0000);
    rd_chk(3'd0, 32'h5000_0000, "R3 uncommitted hold");

    // R8 / R10 internal level source (vector 9)
    src_in[8] = 1'b1;
    @(negedge clk); #1 chk_out(0, 0, "R10 not yet");
    @(negedge clk); #1 chk_out(5, 9, "R8 level active");
    src_in[8] = 1'b0;
    @(negedge clk); @(negedge clk); #1 chk_out(0, 0, "R8 no latch");
    src_in[8] = 1'b1;
    @(negedge clk); @(negedge clk);

    // R5 falling edge on vector 1, R9 tie
    src_in[0] = 1'b1;
    @(negedge clk); rd_chk(3'd0, 32'h5000_0000, "R5 wrong edge ignored");
    src_in[0] = 1'b0;
    @(negedge clk); rd_chk(3'd0, 32'hD000_0000, "R5 falling latched");
    @(negedge clk); #1 chk_out(5, 1, "R9 tie lower vector");

    // R7 acknowledge
    wr(3'd0, 32'hD000_0000);
    rd_chk(3'd0, 32'h5000_0000, "R7 ack clears");
    @(negedge clk); #1 chk_out(5, 9, "R7 after ack");

    // R6 edge while disabled (vector 2)
    src_in[1] = 1'b1;
    @(negedge clk);
    src_in[1] = 1'b0;
    @(negedge clk); rd_chk(3'd0, 32'h5000_0000, "R6 not latched");
    wr(3'd0, 32'h0D00_0000);
    rd_chk(3'd0, 32'h5500_0000, "R6 enable no stale");

    // R9 highest priority (vector 22 at priority 7)
    wr(3'd2, 32'h0000_0F00);
    src_in[21] = 1'b1;
    @(negedge clk); @(negedge clk); #1 chk_out(7, 22, "R9 highest");

    // R2 / R5 polarity: vector 26 rising
    wr(3'd4, 32'h0000_0010);
    rd_chk(3'd4, 32'h0000_0010, "R2 polarity word");
    wr(3'd3, 32'h0D00_0000);
    src_in[25] = 1'b1;
    @(negedge clk); rd_chk(3'd3, 32'h0D00_0000, "R5 rising latched");
    src_in[25] = 1'b0;
    @(negedge clk); rd_chk(3'd3, 32'h0D00_0000, "R5 held");

    // R7 mask all
    for (int a = 0; a < 4; a++) wr(3'(a), 32'h8888_8888);
    @(negedge clk); #1 chk_out(0, 0, "R7 all masked");
    for (int a = 0; a < 4; a++) rd_chk(3'(a), 32'h0, "R7 masked readback");

    // R2 spare fields and spare addresses
    wr(3'd3, 32'hFFFF_FFFF);
    rd_chk(3'd3, 32'h7777_0000, "R2 spare fields");
    wr(3'd5, 32'hFFFF_FFFF);
    rd_chk(3'd5, 32'h0, "R2 spare address");
    rd_chk(3'd4, 32'h0000_0010, "R2 spare write ignored");

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      #1;
      chk("R9 random level", 32'(irq_level), 32'(exp_lvl));
      chk("R9 random vector", 32'(irq_vector), 32'(exp_vec));
      chk("R4 random read", bus_rdata, m_read(bus_addr));
      for (int b = 0; b < NSRC; b++)
        if ($urandom % 8 == 0) src_in[b] = ~src_in[b];
      bus_wr = ($urandom % 4 == 0);
      bus_addr = 3'($urandom % 6);
      bus_wdata = ($urandom % 40 == 0) ? 32'h8888_8888 : $urandom;
    end
    bus_wr = 1'b0;
    done = 1'b1;
    summary();
    $finish;
  end
endmodule